// File: doc/BRIEF.md
# Low-Power Mode Watchdog Controller

This block steps a small processor core between three power modes (run, wait and stop) and runs a fixed-period watchdog counter beside them. Instruction decode raises one-cycle stop or wait requests. The controller answers by gating the oscillator, the CPU clock and the peripheral clock, and it pulses a clear of the interrupt-mask bit so that the core can be woken. Wake-up comes from the external interrupt pin, the external reset pin or the internal interrupt lines. Which of these count depends on the mode.

Leaving stop mode starts a fixed oscillator stabilization delay. During that delay a busy flag is high and the CPU clock stays off. The watchdog is frozen while the core is stopped and starts counting again on the cycle after wake-up. If the wake-up came from the reset pin, the watchdog is cleared again when the delay ends. If it came from the interrupt pin, the watchdog is not cleared at that point.

When the clock monitor is enabled, a stop request does not stop the core. It makes the monitor time out and raise a reset request. Every reset request, from the monitor or from the watchdog, leaves the controller in run mode with all clocks on and the watchdog at zero.

Top module: `lpm_wdog_ctrl`

## Requirements
- R1: After reset, the oscillator, CPU clock and peripheral clock enables are 1, and the stabilization-busy flag, the interrupt-mask clear and both reset requests are 0.
- R2: A wait request in run mode turns the CPU clock enable off from the next cycle. The oscillator and peripheral clock enables stay on.
- R3: A stop request in run mode, with the clock-monitor enable at 0, turns all three clock enables off from the next cycle. The watchdog is set to zero and holds there for as long as the core stays stopped, so the stopped time never leads to a watchdog reset.
- R4: Entering wait mode or stop mode raises the interrupt-mask clear for exactly one cycle, in the first cycle of the new mode. It is not raised at any other time.
- R5: Wait mode returns to run mode, with all clock enables on, one cycle after the interrupt pin, the reset pin or any bit of the internal interrupt request vector is 1.
- R6: Stop mode ends only on the interrupt pin or the reset pin. The internal interrupt requests and new stop or wait requests have no effect in stop mode.
- R7: On wake-up from stop, the busy flag is 1 for exactly STAB_CYC cycles (4064 by default), starting the cycle after the wake input. During those cycles the oscillator enable is 1 and the CPU and peripheral clock enables are 0. In the first cycle after the busy flag falls, all enables are 1.
- R8: The watchdog counts from the cycle that follows the wake-up edge. After an interrupt-pin wake-up it is not cleared when the delay ends, so its reset request comes 2^WDOG_W + 1 clock edges after the wake-up edge, counting that edge as the first.
- R9: After a reset-pin wake-up, the watchdog is cleared on the edge that ends the delay, so its reset request comes STAB_CYC + 2^WDOG_W + 1 edges after the wake-up edge.
- R10: With the clock-monitor enable at 1, a stop request in run mode raises the clock-monitor reset request for exactly one cycle and clears the watchdog. The mode stays run, with all enables on and no interrupt-mask clear.
- R11: The watchdog is WDOG_W bits wide (17 by default) and counts one step on every clock edge outside stop mode. When it wraps from all ones to zero, the watchdog reset request goes high for one cycle, and the next request follows 2^WDOG_W edges later.
- R12: The service strobe clears the watchdog only in run mode, so the reset request comes 2^WDOG_W + 1 edges after the servicing edge. In wait mode the strobe is ignored.
- R13: A watchdog reset request raised in wait mode or during stabilization puts the controller back in run mode with all clock enables on in the same cycle as the request.
- R14: A stop request and a wait request in the same run cycle enter stop mode. Stop and wait requests are ignored outside run mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| stop_req_i | input | 1 | Stop request pulse from instruction decode |
| wait_req_i | input | 1 | Wait request pulse from instruction decode |
| ext_rst_i | input | 1 | Synchronized external reset pin, used as a wake source |
| irq_pin_i | input | 1 | Synchronized external interrupt pin |
| int_req_i | input | N_INT | Enabled internal interrupt requests |
| cme_i | input | 1 | Clock-monitor enable |
| wdog_svc_i | input | 1 | Watchdog service strobe |
| osc_en_o | output | 1 | Oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| clr_imask_o | output | 1 | One-cycle pulse that clears the interrupt-mask bit |
| stab_busy_o | output | 1 | Oscillator stabilization in progress |
| wdog_rst_o | output | 1 | Watchdog reset request |
| cmon_rst_o | output | 1 | Clock-monitor reset request |

## Verification
The properties assume that the reset pin and the interrupt pin arrive already synchronized and are sampled only on clock edges. They also assume that the stop and wait requests come from a core that is running. No property depends on how long a request is held, because every mode change is decided again on each edge. The stimulus drives the wake pins, the requests and the service strobe for a single cycle, between two negative edges. The internal interrupt lines are raised only to show that stop mode ignores them or to end a wait. A narrow watchdog width keeps each overflow window short enough that every timing case can be measured edge by edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2,
    MODE_STAB = 2'd3
  } lpm_mode_e;
endpackage

// File: rtl/lpm_stab_timer.sv
module lpm_stab_timer #(
  parameter int unsigned CYC = 4064,
  parameter int unsigned W   = $clog2(CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= W'(CYC - 1);
    else if (en_i && cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_wdog_cnt.sv
module lpm_wdog_cnt #(
  parameter int unsigned W = 17
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + W'(1);  // wraps to zero on overflow
  end

  assign ovf_o = en_i & (&cnt_q);
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned N_INT = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wait_req_i,
  input  logic             ext_rst_i,
  input  logic             irq_pin_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic             cme_i,
  input  logic             wdog_svc_i,
  input  logic             wdog_ovf_i,
  input  logic             stab_done_i,
  output lpm_mode_e        mode_o,
  output logic             stab_load_o,
  output logic             wdog_clr_o,
  output logic             clr_imask_o,
  output logic             cmon_rst_o
);
  lpm_mode_e mode_q, mode_d;
  logic      wake_rst_q;
  logic      clr_imask_q, cmon_rst_q;
  logic      stop_wake, wait_wake, cmon_hit, stab_end;

  assign stop_wake = ext_rst_i | irq_pin_i;
  assign wait_wake = stop_wake | (|int_req_i);
  assign cmon_hit  = (mode_q == MODE_RUN) & stop_req_i & cme_i;
  assign stab_end  = (mode_q == MODE_STAB) & stab_done_i;

  always_comb begin
    mode_d      = mode_q;
    stab_load_o = 1'b0;
    unique case (mode_q)
      MODE_RUN: begin
        if (!wdog_ovf_i) begin
          if (stop_req_i) begin
            if (!cme_i) mode_d = MODE_STOP;  // enabled monitor resets instead
          end else if (wait_req_i) begin
            mode_d = MODE_WAIT;
          end
        end
      end
      MODE_WAIT: if (wdog_ovf_i || wait_wake) mode_d = MODE_RUN;
      MODE_STOP: begin
        if (stop_wake) begin
          mode_d      = MODE_STAB;
          stab_load_o = 1'b1;
        end
      end
      MODE_STAB: if (wdog_ovf_i || stab_done_i) mode_d = MODE_RUN;
      default:   mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_RUN;
      wake_rst_q  <= 1'b0;
      clr_imask_q <= 1'b0;
      cmon_rst_q  <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      clr_imask_q <= (mode_q == MODE_RUN) &&
                     (mode_d == MODE_WAIT || mode_d == MODE_STOP);
      cmon_rst_q  <= cmon_hit;
      if (mode_q == MODE_STOP && stop_wake) wake_rst_q <= ext_rst_i;
    end
  end

  assign wdog_clr_o = ((mode_q == MODE_RUN) && (mode_d == MODE_STOP))
                    | cmon_hit
                    | ((mode_q == MODE_RUN) & wdog_svc_i)
                    | (stab_end & wake_rst_q);

  assign mode_o      = mode_q;
  assign clr_imask_o = clr_imask_q;
  assign cmon_rst_o  = cmon_rst_q;
endmodule

// File: rtl/lpm_wdog_ctrl.sv
module lpm_wdog_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned WDOG_W   = 17,
  parameter int unsigned STAB_CYC = 4064,
  parameter int unsigned N_INT    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wait_req_i,
  input  logic             ext_rst_i,
  input  logic             irq_pin_i,
  input  logic [N_INT-1:0] int_req_i,
  input  logic             cme_i,
  input  logic             wdog_svc_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic             per_clk_en_o,
  output logic             clr_imask_o,
  output logic             stab_busy_o,
  output logic             wdog_rst_o,
  output logic             cmon_rst_o
);
  localparam int unsigned STAB_W = $clog2(STAB_CYC);

  lpm_mode_e mode;
  logic      stab_load, stab_done, wdog_clr, wdog_ovf, wdog_rst_q;

  lpm_mode_fsm #(.N_INT(N_INT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_req_i  (stop_req_i),
    .wait_req_i  (wait_req_i),
    .ext_rst_i   (ext_rst_i),
    .irq_pin_i   (irq_pin_i),
    .int_req_i   (int_req_i),
    .cme_i       (cme_i),
    .wdog_svc_i  (wdog_svc_i),
    .wdog_ovf_i  (wdog_ovf),
    .stab_done_i (stab_done),
    .mode_o      (mode),
    .stab_load_o (stab_load),
    .wdog_clr_o  (wdog_clr),
    .clr_imask_o (clr_imask_o),
    .cmon_rst_o  (cmon_rst_o)
  );

  lpm_stab_timer #(.CYC(STAB_CYC), .W(STAB_W)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (stab_load),
    .en_i   (mode == MODE_STAB),
    .done_o (stab_done)
  );

  lpm_wdog_cnt #(.W(WDOG_W)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (wdog_clr),
    .en_i   (mode != MODE_STOP),
    .ovf_o  (wdog_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdog_rst_q <= 1'b0;
    else         wdog_rst_q <= wdog_ovf;
  end

  assign osc_en_o     = (mode != MODE_STOP);
  assign cpu_clk_en_o = (mode == MODE_RUN);
  assign per_clk_en_o = (mode == MODE_RUN) || (mode == MODE_WAIT);
  assign stab_busy_o  = (mode == MODE_STAB);
  assign wdog_rst_o   = wdog_rst_q;
endmodule

// File: rtl/lpm_wdog_ctrl_chk.sv
module lpm_wdog_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic stop_req_i,
  input logic cme_i,
  input logic ext_rst_i,
  input logic irq_pin_i,
  input logic osc_en_o,
  input logic cpu_clk_en_o,
  input logic per_clk_en_o,
  input logic clr_imask_o,
  input logic stab_busy_o,
  input logic wdog_rst_o,
  input logic cmon_rst_o
);
  p_stop_clk_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && !per_clk_en_o));

  p_imask_cpu_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_imask_o |-> !cpu_clk_en_o);

  p_imask_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_imask_o |=> !clr_imask_o);

  p_stop_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !ext_rst_i && !irq_pin_i) |=> !osc_en_o);

  p_stab_clk_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stab_busy_o |-> (osc_en_o && !cpu_clk_en_o && !per_clk_en_o));

  p_stab_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stab_busy_o) |-> (cpu_clk_en_o && per_clk_en_o));

  p_cmon_fire_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && stop_req_i && cme_i) |=> (cmon_rst_o && osc_en_o && cpu_clk_en_o));

  p_cmon_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmon_rst_o |=> !cmon_rst_o);

  p_wdog_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |=> !wdog_rst_o);

  p_wdog_run_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_rst_o |-> (osc_en_o && cpu_clk_en_o && per_clk_en_o));
endmodule

bind lpm_wdog_ctrl lpm_wdog_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_req_i   (stop_req_i),
  .cme_i        (cme_i),
  .ext_rst_i    (ext_rst_i),
  .irq_pin_i    (irq_pin_i),
  .osc_en_o     (osc_en_o),
  .cpu_clk_en_o (cpu_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .clr_imask_o  (clr_imask_o),
  .stab_busy_o  (stab_busy_o),
  .wdog_rst_o   (wdog_rst_o),
  .cmon_rst_o   (cmon_rst_o)
);

// File: tb/lpm_wdog_ctrl_bench.sv
module lpm_wdog_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_W     = 13;
  localparam int STAB_CYC   = 4064;
  localparam int N_INT      = 4;
  localparam int WPER       = 1 << WDOG_W;
  localparam int LIMIT      = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_req = 1'b0, wait_req = 1'b0, ext_rst = 1'b0, irq_pin = 1'b0;
  logic [N_INT-1:0] int_req = '0;
  logic cme = 1'b0, svc = 1'b0;
  logic osc_en, cpu_en, per_en, clr_imask, busy, wdog_rst, cmon_rst;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lpm_wdog_ctrl #(.WDOG_W(WDOG_W), .STAB_CYC(STAB_CYC), .N_INT(N_INT)) u_lpm_wdog_ctrl (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .stop_req_i   (stop_req),
    .wait_req_i   (wait_req),
    .ext_rst_i    (ext_rst),
    .irq_pin_i    (irq_pin),
    .int_req_i    (int_req),
    .cme_i        (cme),
    .wdog_svc_i   (svc),
    .osc_en_o     (osc_en),
    .cpu_clk_en_o (cpu_en),
    .per_clk_en_o (per_en),
    .clr_imask_o  (clr_imask),
    .stab_busy_o  (busy),
    .wdog_rst_o   (wdog_rst),
    .cmon_rst_o   (cmon_rst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    edges++;
  endtask

  task automatic run_to_ovf();
    while (!wdog_rst && edges < LIMIT) tick();
  endtask

  task automatic clear_wdog();
    svc = 1'b1;
    edges = 0;
    tick();
    svc = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 osc_en", osc_en, 1);
    chk("R1 cpu_en", cpu_en, 1);
    chk("R1 per_en", per_en, 1);
    chk("R1 busy/imask/resets", {busy, clr_imask, wdog_rst, cmon_rst}, 0);
  endtask

  task automatic enter_wait();
    wait_req = 1'b1;
    tick();
    wait_req = 1'b0;
  endtask

  task automatic t_wait();
    clear_wdog();
    enter_wait();
    chk("R2 wait cpu_en", cpu_en, 0);
    chk("R2 wait osc/per", {osc_en, per_en}, 3);
    chk("R4 imask on wait entry", clr_imask, 1);
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
    chk("R4 imask single pulse", clr_imask, 0);
    tick();
    chk("R14 stop ignored in wait osc", osc_en, 1);
    chk("R14 stop ignored in wait cpu", cpu_en, 0);
    int_req = 4'b0100;
    tick();
    int_req = '0;
    chk("R5 internal wake", {osc_en, cpu_en, per_en}, 7);
    chk("R4 no imask on exit", clr_imask, 0);
    enter_wait();
    irq_pin = 1'b1;
    tick();
    irq_pin = 1'b0;
    chk("R5 irq pin wake", cpu_en, 1);
    enter_wait();
    ext_rst = 1'b1;
    tick();
    ext_rst = 1'b0;
    chk("R5 reset pin wake", cpu_en, 1);
  endtask

  task automatic t_run_ovf();
    clear_wdog();
    run_to_ovf();
    chk("R12 service to overflow edges", edges, WPER + 1);
    chk("R11 overflow request", wdog_rst, 1);
    edges = 0;
    tick();
    chk("R11 request one cycle", wdog_rst, 0);
    run_to_ovf();
    chk("R11 wrap period", edges, WPER);
    repeat (100) tick();
    clear_wdog();
    run_to_ovf();
    chk("R12 late service restarts", edges, WPER + 1);
  endtask

  task automatic t_wait_ovf();
    clear_wdog();
    repeat (4) tick();
    enter_wait();
    chk("R2 in wait", cpu_en, 0);
    repeat (3) begin
      svc = 1'b1;
      tick();
      svc = 1'b0;
      tick();
    end
    run_to_ovf();
    chk("R12 service ignored in wait", edges, WPER + 1);
    chk("R13 wait overflow to run", {osc_en, cpu_en, per_en}, 7);
  endtask

  task automatic t_cme();
    cme = 1'b1;
    stop_req = 1'b1;
    edges = 0;
    tick();
    stop_req = 1'b0;
    chk("R10 monitor reset", cmon_rst, 1);
    chk("R10 stays run", {osc_en, cpu_en, per_en}, 7);
    chk("R10 no imask clear", clr_imask, 0);
    tick();
    chk("R10 monitor pulse one cycle", cmon_rst, 0);
    cme = 1'b0;
    run_to_ovf();
    chk("R10 watchdog cleared", edges, WPER + 1);
  endtask

  task automatic wake_measure(input string tag, input int exp_edges);
    int  busy_n = 1;
    bit  seen_end = 1'b0;
    chk("R7 busy after wake", busy, 1);
    chk("R7 osc on cpu/per off", {osc_en, cpu_en, per_en}, 4);
    while (!wdog_rst && edges < LIMIT) begin
      tick();
      if (busy) busy_n++;
      else if (!seen_end) begin
        seen_end = 1'b1;
        chk("R7 clocks back after delay", {osc_en, cpu_en, per_en}, 7);
      end
    end
    chk("R7 busy length", busy_n, STAB_CYC);
    chk(tag, edges, exp_edges);
  endtask

  task automatic t_stop_irq();
    int stray = 0;
    stop_req = 1'b1;
    tick();
    stop_req = 1'b0;
    chk("R3 stop clocks off", {osc_en, cpu_en, per_en}, 0);
    chk("R4 imask on stop entry", clr_imask, 1);
    tick();
    chk("R4 imask single pulse stop", clr_imask, 0);
    int_req = '1;
    wait_req = 1'b1;
    tick();
    wait_req = 1'b0;
    repeat (4) tick();
    int_req = '0;
    chk("R6 internal ignored in stop", osc_en, 0);
    repeat (WPER + 800) begin
      tick();
      if (wdog_rst) stray++;
    end
    chk("R3 watchdog frozen in stop", stray, 0);
    chk("R6 still stopped", osc_en, 0);
    irq_pin = 1'b1;
    edges = 0;
    tick();
    irq_pin = 1'b0;
    wake_measure("R8 irq wake not cleared", WPER + 1);
  endtask

  task automatic t_stop_rst();
    clear_wdog();
    stop_req = 1'b1;
    wait_req = 1'b1;
    tick();
    stop_req = 1'b0;
    wait_req = 1'b0;
    chk("R14 stop wins over wait", {osc_en, per_en}, 0);
    repeat (20) tick();
    ext_rst = 1'b1;
    edges = 0;
    tick();
    ext_rst = 1'b0;
    wake_measure("R9 reset wake cleared at end", STAB_CYC + WPER + 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_wait();
    t_run_ovf();
    t_wait_ovf();
    t_cme();
    t_stop_irq();
    t_stop_rst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule